// File: doc/BRIEF.md
# Combined Input/Output Queued Cell Switch

This block is an N-port cell switch. Each input port holds one small FIFO for every output port, so traffic for a busy output never blocks cells headed elsewhere. A fabric matcher moves cells from these per-destination input queues into per-output FIFOs. Each output then sends at most one cell per link slot. The fabric runs S matching phases per link slot, with one phase per clock. With S equal to 1 cells pile up only at the inputs. With S equal to the port count they pile up only at the outputs. The default of 2 sits between the two.

The matcher works in one round-robin pass per phase, in three steps. Each output grants one of the inputs that has a cell for it. Each input then accepts one of the grants it received. The pointers of a matched pair then move to one past its partner. Both queue stages drop at the tail when full. Every drop gives a one-cycle pulse and increments a per-port wrapping counter.

Cells are entered only in the first cycle of a slot, which the block flags on `slot_first`. Outputs present cells only in the last cycle of a slot.

Top module: `cioq_switch`

## Requirements
- R1: After reset every input queue and output FIFO is empty, `out_valid`, `in_drop` and `out_drop` are low, every drop counter reads zero, and `slot_first` is high in the first cycle.
- R2: A cell waiting for a busy output does not hold back a later cell from the same input for another, idle output. When an input has been matched most recently to output 0, and a new cell for an idle output 2 arrives, that cell leaves three cycles after it was entered. Cells queued for output 0 do not delay it.
- R3: Cells from one input to one output leave in the order they arrived. The bench places the source input in data bits [7:6] and a per-source sequence number in bits [5:0].
- R4: In every phase each input sends at most one cell and each output receives at most one cell. Every accepted cell is delivered once, on the output named by its destination field.
- R5: `slot_first` is high in one cycle out of every S, and inputs are sampled only in that cycle. With S of 2, `out_valid` is never high while `slot_first` is high.
- R6: A cell that arrives for an input queue already holding VD cells is discarded. `in_drop` of that input pulses in the same cycle, and its counter in `in_drop_cnt` (bits [p*CW +: CW]) increases by one. The queued cells are kept and still leave in order.
- R7: A cell that the fabric moves into an output FIFO that already held OD cells at the start of that phase is discarded. `out_drop` of that output pulses, and its counter in `out_drop_cnt` increases by one.
- R8: Each output has a grant pointer that moves to one past the input it was matched with. Three inputs continuously sending to one output are therefore served in the rotating order 0, 1, 2, 0, 1, 2.
- R9: With S of 2, a cell that meets no contention is entered in the first cycle of a slot. It appears on its output in the last cycle of the next slot, three cycles after it was entered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_first | output | 1 | High in the first cycle of each link slot |
| in_valid | input | N | Per-input cell present, sampled when `slot_first` is high |
| in_dest | input | N*PW | Per-input destination output index |
| in_data | input | N*W | Per-input cell payload |
| out_valid | output | N | Per-output cell leaving this cycle |
| out_data | output | N*W | Per-output cell payload |
| in_drop | output | N | Per-input pulse: arriving cell discarded |
| out_drop | output | N | Per-output pulse: transferred cell discarded |
| in_drop_cnt | output | N*CW | Per-input wrapping count of input drops |
| out_drop_cnt | output | N*CW | Per-output wrapping count of output drops |

## Verification
The assertions check every cycle that each output takes cells from at most one input per phase. They also check that no queue count ever exceeds its depth, and that every drop pulse raises the matching counter by exactly one on the next cycle. Some behaviour shows only across a whole traffic pattern, and the bench scenarios cover it. These are: exact cut-through latency, the rotation order of contending inputs, the escape of a cell past a backlog held for another output, and ordering per source. The bench also checks conservation under overload: every cell entered is either delivered or counted as a drop.

// File: rtl/cioq_switch.sv
module cioq_switch #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int VD = 5,
  parameter int OD = 20,
  parameter int S  = 2,
  parameter int CW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              slot_first,
  input  logic [N-1:0]      in_valid,
  input  logic [N*((N>1)?$clog2(N):1)-1:0] in_dest,
  input  logic [N*W-1:0]    in_data,
  output logic [N-1:0]      out_valid,
  output logic [N*W-1:0]    out_data,
  output logic [N-1:0]      in_drop,
  output logic [N-1:0]      out_drop,
  output logic [N*CW-1:0]   in_drop_cnt,
  output logic [N*CW-1:0]   out_drop_cnt
);
  localparam int PW  = (N > 1) ? $clog2(N) : 1;
  localparam int VAW = (VD > 1) ? $clog2(VD) : 1;
  localparam int VCW = $clog2(VD + 1);
  localparam int OAW = (OD > 1) ? $clog2(OD) : 1;
  localparam int OCW = $clog2(OD + 1);
  localparam int SW  = (S > 1) ? $clog2(S) : 1;

  logic [SW-1:0]  ph;
  logic           arrive, last;

  logic [W-1:0]   vq_mem [N][N][VD];
  logic [VAW-1:0] vq_wp  [N][N];
  logic [VAW-1:0] vq_rp  [N][N];
  logic [VCW-1:0] vq_cnt [N][N];

  logic [W-1:0]   oq_mem [N][OD];
  logic [OAW-1:0] oq_wp  [N];
  logic [OAW-1:0] oq_rp  [N];
  logic [OCW-1:0] oq_cnt [N];

  logic [PW-1:0]  gptr [N];
  logic [PW-1:0]  aptr [N];
  logic [CW-1:0]  idc  [N];
  logic [CW-1:0]  odc  [N];

  logic [N-1:0]   col  [N];
  logic [N-1:0]   gnt  [N];
  logic [N-1:0]   gin  [N];
  logic [N-1:0]   acc  [N];
  logic [N-1:0]   acol [N];
  logic [N-1:0]   vpush [N];
  logic [N-1:0]   mval, opush;
  logic [W-1:0]   mdat [N];

  assign arrive     = (ph == '0);
  assign last       = (ph == SW'(S - 1));
  assign slot_first = arrive;

  function automatic logic [N-1:0] rr_pick(input logic [N-1:0] v, input logic [PW-1:0] p);
    int idx;
    rr_pick = '0;
    for (int k = N - 1; k >= 0; k--) begin
      idx = (int'(p) + k) % N;
      if (v[idx]) begin
        rr_pick = '0;
        rr_pick[idx] = 1'b1;
      end
    end
  endfunction

  always_comb begin
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        col[j][i] = (vq_cnt[i][j] != '0);
    for (int j = 0; j < N; j++)
      gnt[j] = rr_pick(col[j], gptr[j]);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        gin[i][j] = gnt[j][i];
    for (int i = 0; i < N; i++)
      acc[i] = rr_pick(gin[i], aptr[i]);
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        acol[j][i] = acc[i][j];
  end

  always_comb begin
    for (int j = 0; j < N; j++) begin
      mval[j] = 1'b0;
      mdat[j] = '0;
      for (int i = 0; i < N; i++)
        if (acc[i][j]) begin
          mval[j] = 1'b1;
          mdat[j] = vq_mem[i][j][vq_rp[i][j]];
        end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      in_drop[i] = arrive && in_valid[i] &&
                   (vq_cnt[i][in_dest[i*PW +: PW]] == VCW'(VD));
      for (int j = 0; j < N; j++)
        vpush[i][j] = arrive && in_valid[i] && (in_dest[i*PW +: PW] == PW'(j)) &&
                      (vq_cnt[i][j] != VCW'(VD));
      in_drop_cnt[i*CW +: CW] = idc[i];
    end
    for (int j = 0; j < N; j++) begin
      out_valid[j]            = last && (oq_cnt[j] != '0);
      out_data[j*W +: W]      = oq_mem[j][oq_rp[j]];
      out_drop[j]             = mval[j] && (oq_cnt[j] == OCW'(OD));
      opush[j]                = mval[j] && (oq_cnt[j] != OCW'(OD));
      out_drop_cnt[j*CW +: CW] = odc[j];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= '0;
      for (int i = 0; i < N; i++) begin
        gptr[i] <= '0;
        aptr[i] <= '0;
        idc[i]  <= '0;
        odc[i]  <= '0;
        oq_wp[i] <= '0;
        oq_rp[i] <= '0;
        oq_cnt[i] <= '0;
        for (int j = 0; j < N; j++) begin
          vq_wp[i][j]  <= '0;
          vq_rp[i][j]  <= '0;
          vq_cnt[i][j] <= '0;
        end
      end
    end else begin
      ph <= last ? '0 : SW'(ph + 1'b1);
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (vpush[i][j]) begin
            vq_mem[i][j][vq_wp[i][j]] <= in_data[i*W +: W];
            vq_wp[i][j] <= (vq_wp[i][j] == VAW'(VD - 1)) ? '0 : VAW'(vq_wp[i][j] + 1'b1);
          end
          if (acc[i][j]) begin
            vq_rp[i][j] <= (vq_rp[i][j] == VAW'(VD - 1)) ? '0 : VAW'(vq_rp[i][j] + 1'b1);
            aptr[i] <= PW'((j + 1) % N);
            gptr[j] <= PW'((i + 1) % N);
          end
          vq_cnt[i][j] <= vq_cnt[i][j] + VCW'(vpush[i][j]) - VCW'(acc[i][j]);
        end
        if (in_drop[i]) idc[i] <= idc[i] + 1'b1;
      end
      for (int j = 0; j < N; j++) begin
        if (opush[j]) begin
          oq_mem[j][oq_wp[j]] <= mdat[j];
          oq_wp[j] <= (oq_wp[j] == OAW'(OD - 1)) ? '0 : OAW'(oq_wp[j] + 1'b1);
        end
        if (out_valid[j])
          oq_rp[j] <= (oq_rp[j] == OAW'(OD - 1)) ? '0 : OAW'(oq_rp[j] + 1'b1);
        oq_cnt[j] <= oq_cnt[j] + OCW'(opush[j]) - OCW'(out_valid[j]);
        if (out_drop[j]) odc[j] <= odc[j] + 1'b1;
      end
    end
  end

  for (genvar gj = 0; gj < N; gj++) begin : g_ochk
    // R4
    one_src_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(acol[gj]));
    // R7
    oq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) oq_cnt[gj] <= OCW'(OD));
    // R7
    odrop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_drop[gj] |=> odc[gj] == $past(odc[gj]) + CW'(1));
    for (genvar gi = 0; gi < N; gi++) begin : g_vchk
      // R6
      vq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) vq_cnt[gi][gj] <= VCW'(VD));
    end
  end

  for (genvar gi = 0; gi < N; gi++) begin : g_ichk
    // R6
    idrop_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_drop[gi] |=> idc[gi] == $past(idc[gi]) + CW'(1));
  end
endmodule

// File: tb/sim_cioq_switch.sv
`timescale 1ns/1ps
module sim_cioq_switch;
  localparam int N = 4, W = 8, PW = 2, CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic slot_first;
  logic [N-1:0] in_valid, out_valid, in_drop, out_drop;
  logic [N*PW-1:0] in_dest;
  logic [N*W-1:0] in_data, out_data;
  logic [N*CW-1:0] in_drop_cnt, out_drop_cnt;

  always #2 clk = ~clk;

  cioq_switch u0 (
    .clk(clk), .rst_n(rst_n), .slot_first(slot_first),
    .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .in_drop(in_drop), .out_drop(out_drop),
    .in_drop_cnt(in_drop_cnt), .out_drop_cnt(out_drop_cnt));

  typedef struct {
    logic [7:0] d;
    int lo;
    int hi;
    string tag;
  } exp_t;

  exp_t sbq [N][$];
  bit   loose [N];
  int   last_seq [N][N];
  int   cyc = 0, checks = 0, failures = 0;
  int   sent = 0, delivered = 0;
  int   idp [N], odp [N];
  logic [7:0] md;
  exp_t me;
  int   msrc, mseq;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    #1;
    if (rst_n === 1'b1) begin
      for (int j = 0; j < N; j++) begin
        if (in_drop[j]) idp[j]++;
        if (out_drop[j]) odp[j]++;
      end
      if (out_valid != '0) chk(!slot_first, "R5", "output in first cycle of slot", int'(slot_first), 0);
      for (int j = 0; j < N; j++) begin
        if (out_valid[j]) begin
          delivered++;
          md = out_data[j*W +: W];
          if (loose[j]) begin
            msrc = int'(md[7:6]);
            mseq = int'(md[5:0]);
            chk(mseq > last_seq[j][msrc], "R3", "per-source order", mseq, last_seq[j][msrc] + 1);
            last_seq[j][msrc] = mseq;
          end else if (sbq[j].size() == 0) begin
            chk(1'b0, "R4", "unexpected cell", int'(md), -1);
          end else begin
            me = sbq[j].pop_front();
            chk(md == me.d, me.tag, "data", int'(md), int'(me.d));
            chk(cyc >= me.lo && cyc <= me.hi, me.tag, "cycle", cyc, me.lo);
          end
        end
      end
    end
  end

  task automatic next_slot();
    @(negedge clk);
    in_valid = '0;
    while (!slot_first) @(negedge clk);
  endtask

  task automatic put(input int s, input int d, input logic [7:0] x,
                     input int lo_off, input int hi_off, input string tag, input bit track);
    exp_t e;
    in_valid[s] = 1'b1;
    in_dest[s*PW +: PW] = PW'(d);
    in_data[s*W +: W] = x;
    sent++;
    if (track) begin
      e.d = x; e.lo = cyc + lo_off; e.hi = cyc + hi_off; e.tag = tag;
      sbq[d].push_back(e);
    end
  endtask

  task automatic set_loose(input int j);
    loose[j] = 1'b1;
    for (int s = 0; s < N; s++) last_seq[j][s] = -1;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

  initial begin
    int tot_in, tot_out;
    rst_n = 1'b0; in_valid = '0; in_dest = '0; in_data = '0;
    for (int j = 0; j < N; j++) begin idp[j] = 0; odp[j] = 0; loose[j] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_drop_cnt == '0, "R1", "in_drop_cnt after reset", int'(in_drop_cnt), 0);
    chk(out_drop_cnt == '0, "R1", "out_drop_cnt after reset", int'(out_drop_cnt), 0);
    chk(slot_first == 1'b1, "R1", "slot_first after reset", int'(slot_first), 1);
    @(negedge clk); #1;
    chk(slot_first == 1'b0, "R5", "slot_first second cycle", int'(slot_first), 0);
    @(negedge clk); #1;
    chk(slot_first == 1'b1, "R5", "slot_first third cycle", int'(slot_first), 1);

    // R9 / R4: two conflict-free permutations, exact latency
    next_slot();
    put(0, 1, 8'h11, 3, 3, "R9", 1);
    put(1, 2, 8'h22, 3, 3, "R9", 1);
    put(2, 3, 8'h33, 3, 3, "R9", 1);
    put(3, 0, 8'h44, 3, 3, "R9", 1);
    next_slot();
    put(0, 0, 8'h50, 3, 3, "R4", 1);
    put(1, 1, 8'h61, 3, 3, "R4", 1);
    put(2, 2, 8'h72, 3, 3, "R4", 1);
    put(3, 3, 8'h83, 3, 3, "R4", 1);
    repeat (8) next_slot();

    // R3: one flow, five cells in order
    for (int k = 0; k < 5; k++) begin
      next_slot();
      put(2, 1, 8'(8'h40 + k), 3, 3, "R3", 1);
    end
    repeat (8) next_slot();

    // R8: three inputs contend for output 3, rotating service
    for (int s = 0; s < 4; s++) begin
      next_slot();
      for (int src = 0; src < 3; src++)
        put(src, 3, {2'(src), 6'(s)}, 0, 60, "R8", 1);
    end
    repeat (20) next_slot();

    // R2: backlog for output 0, then a cell for idle output 2
    set_loose(0);
    for (int s = 0; s < 12; s++) begin
      next_slot();
      for (int src = 0; src < 3; src++)
        put(src, 0, {2'(src), 6'(s)}, 0, 0, "", 0);
    end
    next_slot();
    put(0, 2, 8'hA5, 3, 3, "R2", 1);
    put(1, 0, {2'd1, 6'd12}, 0, 0, "", 0);
    put(2, 0, {2'd2, 6'd12}, 0, 0, "", 0);
    repeat (50) next_slot();

    // R6 / R7: overload output 0 from all inputs
    set_loose(0);
    for (int s = 0; s < 40; s++) begin
      next_slot();
      for (int src = 0; src < 4; src++)
        put(src, 0, {2'(src), 6'(s)}, 0, 0, "", 0);
    end
    repeat (80) next_slot();
    @(negedge clk); #2;

    tot_in = 0; tot_out = 0;
    for (int j = 0; j < N; j++) begin
      tot_in += idp[j];
      tot_out += odp[j];
      chk(sbq[j].size() == 0, "R4", "undelivered expected cells", sbq[j].size(), 0);
      chk(in_drop_cnt[j*CW +: CW] == CW'(idp[j]), "R6", "input drop counter",
          int'(in_drop_cnt[j*CW +: CW]), idp[j] % 256);
      chk(out_drop_cnt[j*CW +: CW] == CW'(odp[j]), "R7", "output drop counter",
          int'(out_drop_cnt[j*CW +: CW]), odp[j] % 256);
    end
    chk(tot_in > 0, "R6", "input drops under overload", tot_in, 1);
    chk(tot_out > 0, "R7", "output drops under overload", tot_out, 1);
    chk(sent == delivered + tot_in + tot_out, "R6", "cell conservation",
        delivered + tot_in + tot_out, sent);
    summary();
    $finish;
  end
endmodule